// File: doc/BRIEF.md
# Token-Gated Four-Entry Readout Buffer with Double-Rate Serial Output

This block sits between a hit-word assembler and the serial readout pads of a front-end chip. Hit words are pushed into a small buffer that accepts a write in the same cycle that it hands a word to the serializer. Words leave as a bit stream on two data lanes. Each lane carries one bit while the clock is high and a second bit while it is low, so with a 200 MHz clock the two lanes together move 800 Mbps.

Sending is controlled by a token passed along a chain of readout blocks. The block serializes only while it holds the token. Each word goes out in full, and back-to-back words follow with no gap while the buffer holds data. Once the buffer is empty and no word is in flight, the block hands the token to the next block in the chain. A frame strobe marks the first beat of every word. The lanes rest low whenever no word is being sent.

For every lane the block delivers the bit for the high phase and the bit for the low phase as registered pairs. The phase multiplexer and the differential drivers belong to the pad cell.

Top module: `ddr_readout_buffer`

## Requirements
- R1: After reset, both lane pairs, the frame strobe, the token output and the overflow flag are all low.
- R2: The buffer holds up to 4 words and sends them in the order they were written.
- R3: A write while the buffer is full and no word leaves in that cycle is discarded and sets the overflow flag. The flag stays high until reset.
- R4: A write in the same cycle that a word leaves a full buffer is accepted.
- R5: Without the token, no data and no frame strobe appear, and buffered words are kept.
- R6: A word of WORD_W bits takes WORD_W/4 cycles and goes out MSB first. In each cycle, bits are sent in this order: `laneRise[1]`, `laneRise[0]`, `laneFall[1]`, `laneFall[0]`. Lane 1 (index 1) therefore carries odd bit positions and lane 0 carries even ones.
- R7: The frame strobe is high exactly in the cycle that carries a word's first beat.
- R8: While the token is held and the buffer is not empty, a new word begins in the cycle after the previous word's last beat.
- R9: The token output pulses high for one cycle in the cycle after an edge at which the token was present (arriving or held), no word was in flight and the buffer was empty. The token is then released.
- R10: In every cycle that carries no beat, both lane pairs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serializer clock (both phases used at the pad) |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write strobe for a hit word |
| wrData | input | WORD_W | Hit word to store |
| tokenIn | input | 1 | One-cycle token grant from the previous block |
| tokenOut | output | 1 | One-cycle token hand-off to the next block |
| laneRise | output | 2 | Bits for the high clock phase; index 1 = lane 1 |
| laneFall | output | 2 | Bits for the low clock phase; index 1 = lane 1 |
| frame | output | 1 | High on the first beat of each word |
| overflow | output | 1 | Sticky flag: a write was discarded |

## Verification
The checker watches, on every cycle, the properties that need no knowledge of the data:
- the overflow flag never falls;
- the fill level never exceeds the depth;
- the token is passed only after an edge at which the buffer was empty;
- a frame strobe only follows an edge at which the buffer held data;
- frame strobes are never adjacent;
- the lanes are low after every cycle in which the control chose neither load nor shift.

Only the bench scenarios can show the following:
- the reassembled bit order;
- the order in which words are written and sent;
- that a write is accepted during a draining read on a full buffer;
- that words are kept while the token is absent.

// File: rtl/rdbuf_pkg.sv
package rdbuf_pkg;
  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic load;   // pop head word and emit its first beat
    logic shift;  // emit next beat of the word in flight
  } rdbufStrobes_t;
endpackage

// File: rtl/rdbuf_fifo.sv
module rdbuf_fifo #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [WORD_W-1:0] pushData,
  input  logic              pop,
  output logic [WORD_W-1:0] headData,
  output logic [PTR_W:0]    fillLevel
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillLevel <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   fillLevel <= fillLevel + 1'b1;
        2'b01:   fillLevel <= fillLevel - 1'b1;
        default: fillLevel <= fillLevel;
      endcase
    end
  end
endmodule

// File: rtl/rdbuf_datapath.sv
module rdbuf_datapath
  import rdbuf_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [WORD_W-1:0] wrData,
  input  rdbufStrobes_t     strb,
  output logic              empty,
  output logic [PTR_W:0]    fillLevel,
  output logic              overflow,
  output logic [1:0]        laneRise,
  output logic [1:0]        laneFall,
  output logic              frame
);
  logic [WORD_W-1:0] headData;
  logic [WORD_W-1:0] shiftReg;
  logic              full;
  logic              accept;

  assign empty  = (fillLevel == '0);
  assign full   = (fillLevel == (PTR_W+1)'(DEPTH));
  // A pop in the same cycle frees the slot the write needs
  assign accept = wrValid && (!full || strb.load);

  rdbuf_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) i_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (accept),
    .pushData (wrData),
    .pop      (strb.load),
    .headData (headData),
    .fillLevel(fillLevel)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      laneRise <= '0;
      laneFall <= '0;
      frame    <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (wrValid && !accept) overflow <= 1'b1;
      if (strb.load) begin
        laneRise <= headData[WORD_W-1 -: 2];
        laneFall <= headData[WORD_W-3 -: 2];
        shiftReg <= headData << 4;
        frame    <= 1'b1;
      end else if (strb.shift) begin
        laneRise <= shiftReg[WORD_W-1 -: 2];
        laneFall <= shiftReg[WORD_W-3 -: 2];
        shiftReg <= shiftReg << 4;
        frame    <= 1'b0;
      end else begin
        laneRise <= '0;
        laneFall <= '0;
        frame    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rdbuf_ctrl.sv
module rdbuf_ctrl
  import rdbuf_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int BEATS  = WORD_W / 4,
  localparam int BEAT_W = $clog2(BEATS + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tokenIn,
  input  logic          empty,
  output rdbufStrobes_t strb,
  output logic          tokenOut
);
  logic              hasToken;
  logic [BEAT_W-1:0] beatsLeft;
  logic              grant, wordDone, passNow;

  assign grant    = tokenIn || hasToken;
  assign wordDone = (beatsLeft == '0);
  assign passNow  = grant && wordDone && empty;

  always_comb begin
    strb.load  = grant && wordDone && !empty;
    strb.shift = !wordDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hasToken  <= 1'b0;
      beatsLeft <= '0;
      tokenOut  <= 1'b0;
    end else begin
      tokenOut <= passNow;
      if (strb.load) begin
        hasToken  <= 1'b1;
        beatsLeft <= BEAT_W'(BEATS - 1);
      end else if (strb.shift) begin
        beatsLeft <= beatsLeft - 1'b1;
      end
      if (passNow) hasToken <= 1'b0;
    end
  end
endmodule

// File: rtl/ddr_readout_buffer.sv
module ddr_readout_buffer
  import rdbuf_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [WORD_W-1:0] wrData,
  input  logic              tokenIn,
  output logic              tokenOut,
  output logic [1:0]        laneRise,
  output logic [1:0]        laneFall,
  output logic              frame,
  output logic              overflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rdbufStrobes_t     strb;
  logic              empty;
  logic [PTR_W:0]    fillLevel;

  rdbuf_ctrl #(.WORD_W(WORD_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tokenIn (tokenIn),
    .empty   (empty),
    .strb    (strb),
    .tokenOut(tokenOut)
  );

  rdbuf_datapath #(.WORD_W(WORD_W), .DEPTH(DEPTH)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrValid  (wrValid),
    .wrData   (wrData),
    .strb     (strb),
    .empty    (empty),
    .fillLevel(fillLevel),
    .overflow (overflow),
    .laneRise (laneRise),
    .laneFall (laneFall),
    .frame    (frame)
  );
endmodule

// File: rtl/rdbuf_checker.sv
module rdbuf_checker #(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic           clk,
  input logic           rstN,
  input logic           tokenOut,
  input logic           frame,
  input logic [1:0]     laneRise,
  input logic [1:0]     laneFall,
  input logic           overflow,
  input logic           empty,
  input logic [PTR_W:0] fillLevel,
  input logic           stLoad,
  input logic           stShift
);
  // R3
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R2
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= (PTR_W+1)'(DEPTH));

  // R9
  token_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    tokenOut |-> $past(empty));

  // R7
  frame_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    frame |-> !$past(empty));

  // R8
  frame_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    frame |=> !frame);

  // R10
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stLoad && !stShift) |=> (laneRise == 2'b00 && laneFall == 2'b00));
endmodule

bind ddr_readout_buffer rdbuf_checker #(.DEPTH(DEPTH)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tokenOut (tokenOut),
  .frame    (frame),
  .laneRise (laneRise),
  .laneFall (laneFall),
  .overflow (overflow),
  .empty    (empty),
  .fillLevel(fillLevel),
  .stLoad   (strb.load),
  .stShift  (strb.shift)
);

// File: tb/test_ddr_readout_buffer.sv
module test_ddr_readout_buffer;
  localparam int WORD_W = 16;
  localparam int DEPTH  = 4;
  localparam int BEATS  = WORD_W / 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic              wrValid;
  logic [WORD_W-1:0] wrData;
  logic              tokenIn;
  logic              tokenOut;
  logic [1:0]        laneRise, laneFall;
  logic              frame;
  logic              overflow;

  int nChecks = 0;
  int nFails  = 0;
  logic [WORD_W-1:0] expQ [$];

  always #2ns clk = ~clk;

  ddr_readout_buffer #(.WORD_W(WORD_W), .DEPTH(DEPTH)) i_ddr_readout_buffer (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .tokenIn(tokenIn), .tokenOut(tokenOut), .laneRise(laneRise),
    .laneFall(laneFall), .frame(frame), .overflow(overflow)
  );

  task automatic tick();
    @(posedge clk);
    #1ns;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; wrValid = 1'b0; wrData = '0; tokenIn = 1'b0;
    expQ.delete();
    tick(); tick();
    rstN = 1'b1;
  endtask

  task automatic writeWord(input logic [WORD_W-1:0] d, input bit kept);
    wrValid = 1'b1; wrData = d;
    tick();
    wrValid = 1'b0;
    if (kept) expQ.push_back(d);
  endtask

  // Grants token, collects n words, checks framing, order and hand-off
  task automatic drain(input int n, input string tag);
    logic [WORD_W-1:0] got;
    tokenIn = 1'b1;
    tick();
    tokenIn = 1'b0;
    for (int w = 0; w < n; w++) begin
      got = '0;
      for (int b = 0; b < BEATS; b++) begin
        chk({tag, " R7/R8 frame"}, 32'(frame), 32'(b == 0));
        got = {got[WORD_W-5:0], laneRise[1], laneRise[0], laneFall[1], laneFall[0]};
        tick();
      end
      chk({tag, " R2/R6 word"}, 32'(got), 32'(expQ.pop_front()));
    end
    chk({tag, " R9 token passed"}, 32'(tokenOut), 32'd1);
    chk({tag, " R10 lanes idle"}, 32'({laneRise, laneFall, frame}), 32'd0);
    tick();
    chk({tag, " R9 pulse width"}, 32'(tokenOut), 32'd0);
  endtask

  task automatic testReset();
    doReset();
    chk("R1 reset outputs", 32'({laneRise, laneFall, frame, tokenOut, overflow}), 32'd0);
  endtask

  task automatic testSingle();
    doReset();
    writeWord(16'hA5C3, 1);
    drain(1, "single");
  endtask

  task automatic testFullConcurrent();
    doReset();
    writeWord(16'h1234, 1);
    writeWord(16'h8001, 1);
    writeWord(16'hFFFF, 1);
    writeWord(16'h5A0F, 1);
    // Token and write arrive together on a full buffer: R4
    wrValid = 1'b1; wrData = 16'hC0DE; expQ.push_back(16'hC0DE);
    tokenIn = 1'b1;
    tick();
    wrValid = 1'b0;
    tokenIn = 1'b1;
    // Re-enter drain flow: first beat is already out, so collect inline
    tokenIn = 1'b0;
    begin
      logic [WORD_W-1:0] got;
      for (int w = 0; w < 5; w++) begin
        got = '0;
        for (int b = 0; b < BEATS; b++) begin
          chk("R8 back-to-back frame", 32'(frame), 32'(b == 0));
          got = {got[WORD_W-5:0], laneRise[1], laneRise[0], laneFall[1], laneFall[0]};
          tick();
        end
        chk("R4 order incl. concurrent write", 32'(got), 32'(expQ.pop_front()));
      end
    end
    chk("R4 no overflow", 32'(overflow), 32'd0);
    chk("R9 token after full drain", 32'(tokenOut), 32'd1);
    tick();
  endtask

  task automatic testOverflow();
    doReset();
    writeWord(16'h0101, 1);
    writeWord(16'h0202, 1);
    writeWord(16'h0303, 1);
    writeWord(16'h0404, 1);
    chk("R3 not yet overflow", 32'(overflow), 32'd0);
    writeWord(16'hDEAD, 0);
    chk("R3 overflow set", 32'(overflow), 32'd1);
    drain(4, "overflow");
    chk("R3 overflow sticky", 32'(overflow), 32'd1);
  endtask

  task automatic testEmptyPass();
    doReset();
    tokenIn = 1'b1;
    tick();
    tokenIn = 1'b0;
    chk("R9 empty pass", 32'(tokenOut), 32'd1);
    chk("R10 no data on empty pass", 32'({laneRise, laneFall, frame}), 32'd0);
    tick();
    chk("R9 single pulse", 32'(tokenOut), 32'd0);
  endtask

  task automatic testNoToken();
    doReset();
    writeWord(16'h3C96, 1);
    for (int i = 0; i < 6; i++) begin
      chk("R5 silent without token", 32'({laneRise, laneFall, frame, tokenOut}), 32'd0);
      tick();
    end
    drain(1, "R5 word kept");
  endtask

  initial begin
    testReset();
    testSingle();
    testFullConcurrent();
    testOverflow();
    testEmptyPass();
    testNoToken();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule